// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block watches a stream of already-classified instructions as a scheduler packs them into dispatch groups. A group has five slots. Each execution unit kind may appear only a limited number of times in one group. Every cycle the scheduler offers one instruction: a 4-bit unit class, a flag that the instruction writes the count register, a flag that it is an indirect branch through that register, and a flag from an outside address comparator that reports a conflict with an earlier store. The block answers at once, from its current state, with a 2-bit verdict. The verdict is one of three: issue freely, close the group first, or insert a no-op.

The scheduler then pulses `accept` to commit the offered instruction, or `advance` to spend one slot on a no-op or an empty cycle. The block updates its per-unit occupancy on the rising edge. It closes the group when a branch is committed or when the fifth slot is used. Closing the group clears everything it has recorded about that group. Decoding the instructions and comparing the addresses are done outside this block.

Top module: `dgrp_hazard_unit`

## Requirements
- R1: `slots_used` shows how many slots of the open group are filled. It ranges from 0 to 4 and drops back to 0 when the group closes. A group never holds more than five entries.
- R2: The class codes and their per-group quotas are: 1 fixed-point (2), 2 load and 3 store (2 shared between them), 4 floating-point (2), 5 condition-register (1), 6 vector-ALU (1), 7 vector-permute (1), 8 branch (1). An offered instruction whose unit has already reached its quota in the open group reports verdict 1.
- R3: With four slots filled, any offered instruction of classes 1 to 7 reports verdict 1. Only a branch (class 8) may take the fifth slot.
- R4: A committed branch closes the group at the next clock edge, whichever slot it takes. `slots_used` becomes 0.
- R5: If an instruction committed earlier in the open group had `in_ctr_wr` set, an offered branch with `in_ctr_branch` set reports verdict 2.
- R6: If a store was committed earlier in the open group, an offered load with `in_addr_conflict` set reports verdict 2. If no store was committed, the same load reports verdict 0.
- R7: The verdict encoding is 0 = no hazard, 1 = close-group hazard, 2 = no-op hazard. The value 3 never appears. When both a close-group condition and a no-op condition apply, verdict 1 is reported.
- R8: `advance` with `accept` low fills one slot and touches no unit count. When it fills the fifth slot, the group closes. When `accept` is high in the same cycle, `advance` is ignored.
- R9: Class 0 and classes 9 to 15 are pseudo instructions. They report verdict 0, and committing one changes no state.
- R10: When a group closes, the unit counts, the count-register-written flag, the store-seen flag and the slot count are all cleared.
- R11: A synchronous `rst` empties the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_class | input | 4 | Unit class of the offered instruction |
| in_ctr_wr | input | 1 | Offered instruction writes the count register |
| in_ctr_branch | input | 1 | Offered instruction branches through the count register |
| in_addr_conflict | input | 1 | Offered load overlaps the recorded store address |
| accept | input | 1 | Commit the offered instruction this cycle |
| advance | input | 1 | Spend one slot with no unit (no-op or empty cycle) |
| hazard | output | 2 | Verdict for the offered instruction |
| slots_used | output | 3 | Filled slots of the open group |

## Verification
Every ordered pair of the sixteen class codes is tried after a same-class prefix of zero to three entries. This separates quota exhaustion, which depends on the unit and on load and store sharing one quota, from last-slot exhaustion, which depends only on the slot count. A long pseudo-random stream mixes commits, advances and the three flags. It covers cases where several conditions meet: a conflicting load at slot four, a count-register branch after a group was closed by advances, and accept and advance raised together. Short directed runs show that closing a group forgets the recorded store and count-register write, and that a mid-group reset empties the group.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

   localparam int NUM_UNITS = 7;

   // unit indices
   localparam int U_FIX  = 0;
   localparam int U_LS   = 1;
   localparam int U_FLT  = 2;
   localparam int U_CRG  = 3;
   localparam int U_VALU = 4;
   localparam int U_VPRM = 5;
   localparam int U_BR   = 6;

   typedef enum logic [3:0] {
      CL_NONE  = 4'd0,
      CL_FIX   = 4'd1,
      CL_LOAD  = 4'd2,
      CL_STORE = 4'd3,
      CL_FLT   = 4'd4,
      CL_CRG   = 4'd5,
      CL_VALU  = 4'd6,
      CL_VPRM  = 4'd7,
      CL_BR    = 4'd8
   } iclass_e;

   typedef enum logic [1:0] {
      HZ_NONE  = 2'd0,
      HZ_CLOSE = 2'd1,
      HZ_NOOP  = 2'd2
   } hz_e;

   function automatic logic [NUM_UNITS-1:0] unit_onehot(input logic [3:0] c);
      logic [NUM_UNITS-1:0] oh;
      oh = '0;
      case (c)
         CL_FIX:            oh[U_FIX]  = 1'b1;
         CL_LOAD, CL_STORE: oh[U_LS]   = 1'b1;
         CL_FLT:            oh[U_FLT]  = 1'b1;
         CL_CRG:            oh[U_CRG]  = 1'b1;
         CL_VALU:           oh[U_VALU] = 1'b1;
         CL_VPRM:           oh[U_VPRM] = 1'b1;
         CL_BR:             oh[U_BR]   = 1'b1;
         default:           oh = '0;
      endcase
      return oh;
   endfunction

endpackage

// File: rtl/dgrp_classify.sv
module dgrp_classify
   import dgrp_pkg::*;
(
   input  logic [3:0]           cls,
   output logic [NUM_UNITS-1:0] unit_oh,
   output logic                 is_real,
   output logic                 is_branch,
   output logic                 is_load,
   output logic                 is_store
);
   always_comb begin
      unit_oh   = unit_onehot(cls);
      is_real   = |unit_oh;
      is_branch = (cls == CL_BR);
      is_load   = (cls == CL_LOAD);
      is_store  = (cls == CL_STORE);
   end
endmodule

// File: rtl/dgrp_unit_counter.sv
module dgrp_unit_counter #(
   parameter int QUOTA = 2,
   parameter int CW    = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic inc,
   output logic at_quota
);
   if (QUOTA < 1 || QUOTA >= (1 << CW)) begin : g_bad_quota
      $error("dgrp_unit_counter: QUOTA out of range for CW");
   end

   if (QUOTA == 1) begin : g_flag
      logic used;
      always_ff @(posedge clk) begin
         if (rst || clear) used <= 1'b0;
         else if (inc)     used <= 1'b1;
      end
      assign at_quota = used;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst || clear)                   cnt <= '0;
         else if (inc && cnt != {CW{1'b1}})  cnt <= cnt + 1'b1;
      end
      assign at_quota = (cnt >= CW'(QUOTA));
   end
endmodule

// File: rtl/dgrp_slot_tracker.sv
module dgrp_slot_tracker #(
   parameter int SLOTS = 5,
   parameter int SW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          step,
   output logic [SW-1:0] slots,
   output logic          at_last,
   output logic          close
);
   if (SLOTS < 2 || SLOTS > (1 << SW)) begin : g_bad_slots
      $error("dgrp_slot_tracker: SLOTS out of range for SW");
   end

   always_comb begin
      at_last = (slots == SW'(SLOTS - 1));
      close   = flush | (step & at_last);
   end

   always_ff @(posedge clk) begin
      if (rst || close) slots <= '0;
      else if (step)    slots <= slots + 1'b1;
   end
endmodule

// File: rtl/dgrp_hazard_unit.sv
module dgrp_hazard_unit
   import dgrp_pkg::*;
#(
   parameter int SLOTS   = 5,
   parameter int FIX_Q   = 2,
   parameter int LS_Q    = 2,
   parameter int FLT_Q   = 2,
   parameter int CRG_Q   = 1,
   parameter int VALU_Q  = 1,
   parameter int VPRM_Q  = 1,
   localparam int SW     = $clog2(SLOTS),
   localparam int CW     = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [3:0]    in_class,
   input  logic          in_ctr_wr,
   input  logic          in_ctr_branch,
   input  logic          in_addr_conflict,
   input  logic          accept,
   input  logic          advance,
   output logic [1:0]    hazard,
   output logic [SW-1:0] slots_used
);
   function automatic int quota_of(input int u);
      case (u)
         U_FIX:   return FIX_Q;
         U_LS:    return LS_Q;
         U_FLT:   return FLT_Q;
         U_CRG:   return CRG_Q;
         U_VALU:  return VALU_Q;
         U_VPRM:  return VPRM_Q;
         default: return 1;
      endcase
   endfunction

   logic [NUM_UNITS-1:0] unit_oh;
   logic [NUM_UNITS-1:0] full;
   logic is_real, is_branch, is_load, is_store;
   logic take, step, flush, close, at_last;
   logic ctr_set, store_seen, quota_hit;
   hz_e  hz;

   dgrp_classify u_cls (
      .cls       (in_class),
      .unit_oh   (unit_oh),
      .is_real   (is_real),
      .is_branch (is_branch),
      .is_load   (is_load),
      .is_store  (is_store)
   );

   // commit path: accept wins over advance
   always_comb begin
      take  = accept & is_real;
      flush = take & is_branch;
      step  = (take & ~is_branch) | (advance & ~accept);
   end

   dgrp_slot_tracker #(.SLOTS(SLOTS), .SW(SW)) u_slots (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .step    (step),
      .slots   (slots_used),
      .at_last (at_last),
      .close   (close)
   );

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      dgrp_unit_counter #(.QUOTA(quota_of(g)), .CW(CW)) u_cnt (
         .clk      (clk),
         .rst      (rst),
         .clear    (close),
         .inc      (take & unit_oh[g]),
         .at_quota (full[g])
      );
   end

   // per-group structural flags
   always_ff @(posedge clk) begin
      if (rst || close) begin
         ctr_set    <= 1'b0;
         store_seen <= 1'b0;
      end else if (take) begin
         ctr_set    <= ctr_set | in_ctr_wr;
         store_seen <= store_seen | is_store;
      end
   end

   assign quota_hit = |(unit_oh & full);

   always_comb begin
      hz = HZ_NONE;
      if (is_real) begin
         if (quota_hit || (at_last && !is_branch))
            hz = HZ_CLOSE;
         else if ((is_branch && in_ctr_branch && ctr_set) ||
                  (is_load && store_seen && in_addr_conflict))
            hz = HZ_NOOP;
      end
   end

   assign hazard = hz;
endmodule

// File: rtl/dgrp_hazard_checker.sv
module dgrp_hazard_checker #(
   parameter int SLOTS = 5,
   parameter int SW    = 3
) (
   input logic          clk,
   input logic          rst,
   input logic [3:0]    in_class,
   input logic          accept,
   input logic          advance,
   input logic [1:0]    hazard,
   input logic [SW-1:0] slots_used
);
   logic cls_pseudo, cls_nonbr;
   assign cls_pseudo = (in_class == 4'd0) || (in_class > 4'd8);
   assign cls_nonbr  = (in_class >= 4'd1) && (in_class <= 4'd7);

   // R1 slot count never reaches the group size
   a_r1_slot_bound: assert property (@(posedge clk) disable iff (rst)
      slots_used < SW'(SLOTS));

   // R3 last slot is reserved for branches
   a_r3_last_slot: assert property (@(posedge clk) disable iff (rst)
      (slots_used == SW'(SLOTS - 1) && cls_nonbr) |-> hazard == 2'd1);

   // R4 committed branch closes the group
   a_r4_branch_close: assert property (@(posedge clk) disable iff (rst)
      (accept && in_class == 4'd8) |=> slots_used == '0);

   // R7 verdict encoding
   a_r7_encoding: assert property (@(posedge clk) disable iff (rst)
      hazard != 2'd3);

   // R8 advance fills one slot
   a_r8_advance_step: assert property (@(posedge clk) disable iff (rst)
      (advance && !accept && slots_used < SW'(SLOTS - 1)) |=>
         slots_used == $past(slots_used) + 1'b1);

   // R9 pseudo instruction leaves state alone
   a_r9_pseudo_hold: assert property (@(posedge clk) disable iff (rst)
      (accept && cls_pseudo) |=> $stable(slots_used));

   // R9 pseudo instruction reports no hazard
   a_r9_pseudo_clear: assert property (@(posedge clk) disable iff (rst)
      cls_pseudo |-> hazard == 2'd0);

   // R11 reset empties the group
   a_r11_reset: assert property (@(posedge clk)
      rst |=> slots_used == '0);
endmodule

bind dgrp_hazard_unit dgrp_hazard_checker #(.SLOTS(SLOTS), .SW(SW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_class   (in_class),
   .accept     (accept),
   .advance    (advance),
   .hazard     (hazard),
   .slots_used (slots_used)
);

// File: tb/dgrp_hazard_unit_bench.sv
`timescale 1ns/1ps
module dgrp_hazard_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] in_class = '0;
   logic       in_ctr_wr = 1'b0, in_ctr_branch = 1'b0, in_addr_conflict = 1'b0;
   logic       accept = 1'b0, advance = 1'b0;
   logic [1:0] hazard;
   logic [2:0] slots_used;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;   // 250 MHz

   dgrp_hazard_unit u_dgrp_hazard_unit (
      .clk(clk), .rst(rst), .in_class(in_class), .in_ctr_wr(in_ctr_wr),
      .in_ctr_branch(in_ctr_branch), .in_addr_conflict(in_addr_conflict),
      .accept(accept), .advance(advance), .hazard(hazard), .slots_used(slots_used)
   );

   // reference state, from the requirements
   int m_slots;
   int m_cnt[7];
   bit m_ctr, m_st;
   int quota[7] = '{2, 2, 2, 1, 1, 1, 1};

   function automatic int unit_of(input int c);
      case (c)
         1: return 0;
         2, 3: return 1;
         4: return 2;
         5: return 3;
         6: return 4;
         7: return 5;
         8: return 6;
         default: return -1;
      endcase
   endfunction

   task automatic m_clear();
      m_slots = 0; m_ctr = 0; m_st = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int exp_hz(input int c, input bit cb, input bit cf, output string tag);
      int u = unit_of(c);
      tag = "R7";
      if (u < 0) begin tag = "R9"; return 0; end
      if (m_cnt[u] >= quota[u]) begin tag = "R2"; return 1; end
      if (m_slots == 4 && c != 8) begin tag = "R3"; return 1; end
      if (c == 8 && cb && m_ctr) begin tag = "R5"; return 2; end
      if (c == 2 && m_st && cf) begin tag = "R6"; return 2; end
      return 0;
   endfunction

   // one cycle: drive at negedge, check verdict, clock, check slot count
   task automatic step(input int c, input bit cw, input bit cb, input bit cf,
                       input bit acc, input bit adv);
      string tag, stag;
      int    e;
      @(negedge clk);
      in_class = 4'(c); in_ctr_wr = cw; in_ctr_branch = cb;
      in_addr_conflict = cf; accept = acc; advance = adv;
      #0.5;
      e = exp_hz(c, cb, cf, tag);
      check(tag, int'(hazard), e);
      stag = "R1";
      if (acc) begin
         if (unit_of(c) < 0) stag = "R9";
         else if (c == 8) begin m_clear(); stag = "R4"; end
         else begin
            m_cnt[unit_of(c)]++;
            if (cw) m_ctr = 1;
            if (c == 3) m_st = 1;
            m_slots++;
            if (m_slots == 5) begin m_clear(); stag = "R10"; end
         end
      end else if (adv) begin
         m_slots++; stag = "R8";
         if (m_slots == 5) m_clear();
      end
      @(posedge clk); #0.5;
      check(stag, int'(slots_used), m_slots);
      accept = 0; advance = 0;
   endtask

   task automatic close_group();
      step(8, 0, 0, 0, 1, 0);
   endtask

   initial begin : watchdog
      #600000;
      fails++; checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      m_clear();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      #0.5;
      check("R11", int'(slots_used), 0);
      check("R7", int'(hazard), 0);

      // pair sweep: prefix of k same-class entries, then offer b
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int k = 0; k < 4; k++) begin
               close_group();
               for (int j = 0; j < k; j++) step(a, 0, 0, 0, (a != 8), 0);
               step(b, 0, 0, 1, 0, 0);
            end

      // R5 count-register write then indirect branch
      close_group();
      step(1, 1, 0, 0, 1, 0);
      step(8, 0, 1, 0, 0, 0);
      step(8, 0, 0, 0, 0, 0);
      // R6 store then conflicting load, and R7 priority at slot four
      close_group();
      step(2, 0, 0, 1, 0, 0);
      step(3, 0, 0, 0, 1, 0);
      step(2, 0, 0, 1, 0, 0);
      step(1, 0, 0, 0, 1, 0);
      step(4, 0, 0, 0, 1, 0);
      step(6, 0, 0, 0, 1, 0);
      step(2, 0, 0, 1, 0, 0);
      // R10 advances close the group and forget flags
      close_group();
      step(1, 1, 0, 0, 1, 0);
      step(3, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1);
      step(8, 0, 1, 0, 0, 0);
      step(2, 0, 0, 1, 0, 0);
      // R8 accept and advance together: advance ignored
      step(0, 0, 0, 0, 1, 1);
      step(5, 0, 0, 0, 1, 1);
      // R11 reset mid-group
      step(1, 1, 0, 0, 1, 0);
      step(3, 0, 0, 0, 1, 0);
      @(negedge clk); rst = 1;
      @(posedge clk); #0.5;
      m_clear();
      check("R11", int'(slots_used), 0);
      @(negedge clk); rst = 0;
      step(8, 0, 1, 0, 0, 0);
      step(2, 0, 0, 1, 0, 0);

      // pseudo-random mix
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(int'(lfsr[3:0] % 10), lfsr[4], lfsr[5], lfsr[6],
              lfsr[9:7] != 3'd0, lfsr[11:10] == 2'd0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule